// File: doc/BRIEF.md
# UART Channel Sleep Controller

This block decides, for a single UART channel, when the channel may drop into its low-power sleep state and when it has to come back out. Software asks for sleep by setting a request bit in the interrupt enable register. Which bit carries the request depends on the selected compatibility mode. The controller holds that register and tests eight idle conditions every cycle. The conditions cover the transmit path, the receive path, the serial input line, loopback, unacknowledged modem deltas, pending interrupts and IrDA mode. A registered sleep output is raised only while the request is set and every condition holds. That output can drive a clock gate elsewhere in the channel.

The controller runs on an always-on clock, so a falling serial input or new line activity is seen without any gated clock. When any condition fails, the channel wakes on its own one cycle later. It also wakes one cycle after software writes the request bit to zero. The request bit reads back as 1 only while the channel is actually asleep, so software learns whether the request succeeded. All other enable bits read back exactly as written, and they are kept while the channel sleeps.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After synchronous reset, `sleep_o` is 0 and `ier_rdata` is 8'h00.
- R2: Mode encoding on `cmode`: 2'b00 and 2'b10 (the 650-style and 950-style modes) and 2'b11 take the request from IER bit 4. 2'b01 (the 750-style mode) takes it from IER bit 5.
- R3: If the request bit is 1 and every idle condition holds, `sleep_o` is 1 after the next rising clock edge. The request bit counts as 1 when it is written as 1 in that cycle, or when it was stored as 1 earlier.
- R4: Each idle condition alone keeps or drives `sleep_o` to 0. The conditions are: `tx_shift_empty`=1, `tx_fifo_empty`=1, `sin`=1, `rx_idle`=1, `rx_fifo_empty`=1, `loopback`=0, `modem_delta`=4'b0000 and `irq_pending`=0.
- R5: While `irda_mode` is 1, `sleep_o` is 0 after the next edge, whatever the other inputs are.
- R6: When any condition fails during sleep, `sleep_o` falls after the next edge. If the conditions return while the request is still stored, sleep is entered again with no new write.
- R7: A write that sets the active request bit to 0 makes `sleep_o` 0 after that edge.
- R8: In `ier_rdata`, the bit at the active request position equals `sleep_o`.
- R9: Every bit of `ier_rdata` other than the active request position returns the last value written, during sleep and outside it. This includes the inactive candidate bit (bit 5 in the bit-4 modes, bit 4 in the bit-5 mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| cmode | input | 2 | Compatibility mode selector |
| irda_mode | input | 1 | IrDA mode is active |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| ier_rdata | output | 8 | Enable register readback with the request bit replaced by sleep status |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| sin | input | 1 | Serial input line level |
| rx_idle | input | 1 | Receiver state machine is idle |
| rx_fifo_empty | input | 1 | Receive FIFO holds no data |
| loopback | input | 1 | Local loopback is enabled |
| modem_delta | input | 4 | Unacknowledged modem status change flags |
| irq_pending | input | 1 | An interrupt is pending |
| sleep_o | output | 1 | Channel is asleep (registered) |

## Verification
The checker uses the request bit only when it is written in the same cycle, because the stored request is not visible at the ports. Entry and manual wake are therefore asserted on write cycles, and blocking and automatic wake are asserted on any cycle. The checker also assumes that `cmode` stays fixed between a write and the following cycle, since the request position follows the mode combinationally. The stimulus changes the mode only in the same cycle as a fresh write and holds it for the check that follows. All inputs are driven on the falling edge, so each registered result is sampled one full cycle after its cause.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;

    localparam int IER_W      = 8;
    localparam int DELTA_W    = 4;
    localparam int REQ_POS_LO = 4;
    localparam int REQ_POS_HI = 5;
    localparam int POS_W      = $clog2(IER_W);

    typedef enum logic [1:0] {
        CM_STD   = 2'b00,
        CM_WIDE  = 2'b01,
        CM_ENH   = 2'b10,
        CM_SPARE = 2'b11
    } cmode_t;

    typedef struct packed {
        logic tx_shift_empty;
        logic tx_fifo_empty;
        logic sin_high;
        logic rx_idle;
        logic rx_fifo_empty;
        logic no_loopback;
        logic deltas_clear;
        logic no_irq;
    } idle_vec_t;

    localparam int N_COND = $bits(idle_vec_t);

    function automatic logic [POS_W-1:0] req_pos(input cmode_t m);
        return (m == CM_WIDE) ? POS_W'(REQ_POS_HI) : POS_W'(REQ_POS_LO);
    endfunction

endpackage

// File: rtl/uart_sleep_reqreg.sv
module uart_sleep_reqreg
    import uart_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmode_t           mode,
    input  logic             wr,
    input  logic [IER_W-1:0] wdata,
    input  logic             asleep,
    output logic             req_eff,
    output logic [IER_W-1:0] rdata
);
    logic [IER_W-1:0] ier_q;
    logic [POS_W-1:0] pos;

    assign pos = req_pos(mode);

    always_ff @(posedge clk) begin
        if (rst)
            ier_q <= '0;
        else if (wr)
            ier_q <= wdata;
    end

    // Request as seen at the next edge: a write in flight wins.
    assign req_eff = wr ? wdata[pos] : ier_q[pos];

    always_comb begin
        for (int i = 0; i < IER_W; i++)
            rdata[i] = (i == int'(pos)) ? asleep : ier_q[i];
    end
endmodule

// File: rtl/uart_sleep_idle.sv
module uart_sleep_idle
    import uart_sleep_pkg::*;
(
    input  logic               tx_shift_empty,
    input  logic               tx_fifo_empty,
    input  logic               sin,
    input  logic               rx_idle,
    input  logic               rx_fifo_empty,
    input  logic               loopback,
    input  logic [DELTA_W-1:0] modem_delta,
    input  logic               irq_pending,
    output logic               all_idle
);
    idle_vec_t        cond;
    logic [DELTA_W:0] delta_or;

    assign delta_or[0] = 1'b0;
    for (genvar g = 0; g < DELTA_W; g++) begin : g_delta
        assign delta_or[g+1] = delta_or[g] | modem_delta[g];
    end

    always_comb begin
        cond.tx_shift_empty = tx_shift_empty;
        cond.tx_fifo_empty  = tx_fifo_empty;
        cond.sin_high       = sin;
        cond.rx_idle        = rx_idle;
        cond.rx_fifo_empty  = rx_fifo_empty;
        cond.no_loopback    = ~loopback;
        cond.deltas_clear   = ~delta_or[DELTA_W];
        cond.no_irq         = ~irq_pending;
    end

    assign all_idle = &cond;
endmodule

// File: rtl/uart_sleep_state.sv
module uart_sleep_state (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic idle,
    input  logic irda,
    output logic asleep
);
    logic asleep_q;

    always_ff @(posedge clk) begin
        if (rst)
            asleep_q <= 1'b0;
        else
            asleep_q <= req & idle & ~irda;
    end

    assign asleep = asleep_q;
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_sleep_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cmode,
    input  logic               irda_mode,
    input  logic               ier_wr,
    input  logic [IER_W-1:0]   ier_wdata,
    output logic [IER_W-1:0]   ier_rdata,
    input  logic               tx_shift_empty,
    input  logic               tx_fifo_empty,
    input  logic               sin,
    input  logic               rx_idle,
    input  logic               rx_fifo_empty,
    input  logic               loopback,
    input  logic [DELTA_W-1:0] modem_delta,
    input  logic               irq_pending,
    output logic               sleep_o
);
    logic req_eff;
    logic all_idle;
    logic asleep;

    uart_sleep_reqreg u_req (
        .clk    (clk),
        .rst    (rst),
        .mode   (cmode_t'(cmode)),
        .wr     (ier_wr),
        .wdata  (ier_wdata),
        .asleep (asleep),
        .req_eff(req_eff),
        .rdata  (ier_rdata)
    );

    uart_sleep_idle u_idle (
        .tx_shift_empty(tx_shift_empty),
        .tx_fifo_empty (tx_fifo_empty),
        .sin           (sin),
        .rx_idle       (rx_idle),
        .rx_fifo_empty (rx_fifo_empty),
        .loopback      (loopback),
        .modem_delta   (modem_delta),
        .irq_pending   (irq_pending),
        .all_idle      (all_idle)
    );

    uart_sleep_state u_state (
        .clk   (clk),
        .rst   (rst),
        .req   (req_eff),
        .idle  (all_idle),
        .irda  (irda_mode),
        .asleep(asleep)
    );

    assign sleep_o = asleep;
endmodule

// File: rtl/uart_sleep_chk.sv
module uart_sleep_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmode,
    input logic       irda_mode,
    input logic       ier_wr,
    input logic [7:0] ier_wdata,
    input logic [7:0] ier_rdata,
    input logic       tx_shift_empty,
    input logic       tx_fifo_empty,
    input logic       sin,
    input logic       rx_idle,
    input logic       rx_fifo_empty,
    input logic       loopback,
    input logic [3:0] modem_delta,
    input logic       irq_pending,
    input logic       sleep_o
);
    logic [2:0] p;
    logic       quiet;

    assign p     = (cmode == 2'b01) ? 3'd5 : 3'd4;
    assign quiet = tx_shift_empty && tx_fifo_empty && sin && rx_idle &&
                   rx_fifo_empty && !loopback && (modem_delta == 4'b0) && !irq_pending;

    AST_ENTRY_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        (ier_wr && ier_wdata[p] && quiet && !irda_mode) |=> sleep_o); // R3

    AST_BLOCKED_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        !quiet |=> !sleep_o); // R4

    AST_IRDA_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        irda_mode |=> !sleep_o); // R5

    AST_AUTO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && !quiet) |=> !sleep_o); // R6

    AST_MANUAL_WAKE: assert property (@(posedge clk) disable iff (rst)
        (ier_wr && !ier_wdata[p]) |=> !sleep_o); // R7

    AST_READBACK_TRACKS: assert property (@(posedge clk) disable iff (rst)
        ier_rdata[p] == sleep_o); // R8
endmodule

bind uart_sleep_ctrl uart_sleep_chk u_chk (
    .clk(clk), .rst(rst), .cmode(cmode), .irda_mode(irda_mode),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
    .tx_shift_empty(tx_shift_empty), .tx_fifo_empty(tx_fifo_empty),
    .sin(sin), .rx_idle(rx_idle), .rx_fifo_empty(rx_fifo_empty),
    .loopback(loopback), .modem_delta(modem_delta),
    .irq_pending(irq_pending), .sleep_o(sleep_o)
);

// File: tb/uart_sleep_ctrl_test.sv
module uart_sleep_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cmode;
    logic       irda_mode;
    logic       ier_wr;
    logic [7:0] ier_wdata;
    logic [7:0] ier_rdata;
    logic       tx_shift_empty, tx_fifo_empty, sin, rx_idle, rx_fifo_empty, loopback;
    logic [3:0] modem_delta;
    logic       irq_pending;
    logic       sleep_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    uart_sleep_ctrl uut (
        .clk(clk), .rst(rst), .cmode(cmode), .irda_mode(irda_mode),
        .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
        .tx_shift_empty(tx_shift_empty), .tx_fifo_empty(tx_fifo_empty),
        .sin(sin), .rx_idle(rx_idle), .rx_fifo_empty(rx_fifo_empty),
        .loopback(loopback), .modem_delta(modem_delta),
        .irq_pending(irq_pending), .sleep_o(sleep_o)
    );

    // {mode[1:0], irda, txsh, txf, sin, rxidle, rxfe, loop, delta[3:0], irq, req, expected}
    localparam logic [15:0] VEC [13] = '{
        16'b00_0_11111_0_0000_0_1_1, // R2 bit-4 mode, all idle
        16'b01_0_11111_0_0000_0_1_1, // R2 bit-5 mode, all idle
        16'b10_0_11111_0_0000_0_1_1, // R2 other bit-4 mode
        16'b00_0_01111_0_0000_0_1_0, // R4 shift register busy
        16'b00_0_10111_0_0000_0_1_0, // R4 tx fifo not empty
        16'b00_0_11011_0_0000_0_1_0, // R4 sin low
        16'b00_0_11101_0_0000_0_1_0, // R4 receiver busy
        16'b00_0_11110_0_0000_0_1_0, // R4 rx fifo holds data
        16'b00_0_11111_1_0000_0_1_0, // R4 loopback on
        16'b00_0_11111_0_0100_0_1_0, // R4 modem delta set
        16'b00_0_11111_0_0000_1_1_0, // R4 interrupt pending
        16'b00_1_11111_0_0000_0_1_0, // R5 irda selected
        16'b00_0_11111_0_0000_0_0_0  // R3 no request
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_idle();
        irda_mode = 0; tx_shift_empty = 1; tx_fifo_empty = 1; sin = 1;
        rx_idle = 1; rx_fifo_empty = 1; loopback = 0; modem_delta = 0; irq_pending = 0;
    endtask

    task automatic write_ier(input logic [7:0] d);
        ier_wr = 1; ier_wdata = d;
        @(negedge clk);
        ier_wr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cmode = 2'b00; ier_wr = 0; ier_wdata = 0;
        set_idle();
        repeat (3) @(negedge clk);
        check("R1 sleep", {7'b0, sleep_o}, 8'h00);
        check("R1 readback", ier_rdata, 8'h00);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < 13; i++) begin
            logic [15:0] v;
            logic [2:0]  pos;
            string       tag;
            v = VEC[i];
            cmode = v[15:14]; irda_mode = v[13];
            tx_shift_empty = v[12]; tx_fifo_empty = v[11]; sin = v[10];
            rx_idle = v[9]; rx_fifo_empty = v[8]; loopback = v[7];
            modem_delta = v[6:3]; irq_pending = v[2];
            pos = (v[15:14] == 2'b01) ? 3'd5 : 3'd4;
            tag = (i < 3) ? "R2" : (i == 11) ? "R5" : (i == 12) ? "R3" : "R4";
            write_ier(8'(v[1]) << pos);
            check($sformatf("%s vec %0d sleep", tag, i), {7'b0, sleep_o}, {7'b0, v[0]});
            check($sformatf("R8 vec %0d readback", i), {7'b0, ier_rdata[pos]}, {7'b0, v[0]});
        end

        // R6 automatic wake and re-entry with stored request
        cmode = 2'b00; set_idle();
        write_ier(8'h10);
        check("R3 entry", {7'b0, sleep_o}, 8'h01);
        sin = 0;
        @(negedge clk);
        check("R6 wake on sin low", {7'b0, sleep_o}, 8'h00);
        sin = 1;
        @(negedge clk);
        check("R6 re-entry", {7'b0, sleep_o}, 8'h01);

        // R7 manual wake
        write_ier(8'h00);
        check("R7 manual wake", {7'b0, sleep_o}, 8'h00);

        // R9 other bits stored through sleep, bit-4 mode
        write_ier(8'h2F);
        check("R9 not asleep readback", ier_rdata, 8'h2F);
        write_ier(8'h3F);
        check("R9 asleep readback", ier_rdata, 8'h3F);
        irq_pending = 1;
        @(negedge clk);
        check("R9 woken readback", ier_rdata, 8'h2F);
        irq_pending = 0;

        // R2/R9 bit-5 mode: bit 4 is plain storage
        cmode = 2'b01;
        write_ier(8'h10);
        check("R2 bit4 ignored in bit-5 mode", {7'b0, sleep_o}, 8'h00);
        check("R9 bit4 kept in bit-5 mode", ier_rdata, 8'h10);

        // R1 reset during sleep
        write_ier(8'h20);
        check("R2 bit-5 entry", {7'b0, sleep_o}, 8'h01);
        rst = 1;
        @(negedge clk);
        check("R1 reset clears sleep", {7'b0, sleep_o}, 8'h00);
        check("R1 reset clears register", ier_rdata, 8'h00);
        rst = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule